// File: doc/BRIEF.md
# Parallel flash command decoder

This block tracks the write cycles that a host issues to a word-wide parallel NOR flash model and decides what the next reads return. A small state machine matches the two-write unlock prefix and the command byte that follows it. It switches between four read views: plain array contents, the device identifier, the query signature, and unlock-bypass. Bypass is a mode in which programs skip the unlock prefix.

Programming requests leave the decoder as a one-cycle pulse that carries the target word and its data. The same pulse updates a behavioural word array inside the block. That array can only clear bits, the way real flash cells do. Erase, busy status and the full query table belong to neighbouring blocks.

The behavioural array covers the low `MEM_AW` address bits, so higher addresses alias onto it. Reads are registered: `rd_en` in one cycle makes `rdata` valid after that clock edge, and `rdata` then holds until the next read.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `rdata` is 0, `prog_req` is 0, the decoder is in array view, and every array word reads 0xFFFF.
- R2: In array view, writing 0xAA at word 0x555, then 0x55 at 0x2AA, then 0x90 at 0x555 enters identifier view. In that view word 0 reads 0x00BF, word 1 reads 0x236D, and every other word reads 0.
- R3: Writing command 0x98 at word 0x55 enters query view, either from array view or from identifier view. In query view words 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059, and every other word reads 0.
- R4: Writing command 0xF0 in query view returns to identifier view if query view was entered from identifier view, and to array view otherwise. Writing 0xF0 in identifier view returns to array view.
- R5: The sequence unlock pair, 0xA0 at 0x555, then a data write at any address produces exactly one `prog_req` pulse in the cycle after the data write. The pulse carries that write's address and data, and the word becomes readable in array view one cycle later.
- R6: A program stores the bitwise AND of the old word and the new data. For example, 0x0055 followed by 0x00A5 at the same word reads back 0x0005.
- R7: The unlock pair followed by 0x20 at 0x555 enters bypass view. In bypass view, 0xA0 at any address followed by a data write programs a word without an unlock pair, and the decoder stays in bypass view.
- R8: Writing 0x00 in bypass view returns to array view. A following 0xA0 and data write without an unlock pair then programs nothing, and the word keeps 0xFFFF.
- R9: Command matching uses only the low 11 address bits and the low 8 data bits. So words 0x5555 and 0x2AAA act as 0x555 and 0x2AA.
- R10: A write that does not fit the expected unlock or command step returns the decoder to array view and raises no program request. Without a write, the view never changes.
- R11: `rdata` changes only in the cycle after `rd_en` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one word per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data from the current view |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Word address of the program request |
| prog_data | output | 16 | Data of the program request |

## Verification
A wrong view or a wrong step inside the decoder stays hidden until the host reads or programs. The first read after the faulty write then returns array data in place of an identifier or signature word, or the reverse. A sequence step that was skipped or kept too long shows as a missing or stray `prog_req` one cycle after the data write, or as an array word that still holds 0xFFFF. Because a reference model predicts `rdata` and the program pulse on every clock, a divergence is reported in the cycle it reaches a port rather than at the end of a scenario.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int DATA_W     = 16;
    localparam int CMD_ADDR_W = 11;

    typedef enum logic [1:0] {
        VIEW_ARRAY,
        VIEW_IDENT,
        VIEW_QUERY,
        VIEW_BYPASS
    } view_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_GOT_FIRST,
        SEQ_GOT_SECOND,
        SEQ_WAIT_DATA,
        SEQ_WAIT_BYP_DATA
    } seq_e;

    typedef struct packed {
        logic [7:0]            code;
        logic [CMD_ADDR_W-1:0] loc;
    } bus_cmd_t;

    localparam logic [CMD_ADDR_W-1:0] LOC_KEY_A = 11'h555;
    localparam logic [CMD_ADDR_W-1:0] LOC_KEY_B = 11'h2AA;
    localparam logic [CMD_ADDR_W-1:0] LOC_QUERY = 11'h055;

    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_IDENT   = 8'h90;
    localparam logic [7:0] CODE_QUERY   = 8'h98;
    localparam logic [7:0] CODE_EXIT    = 8'hF0;
    localparam logic [7:0] CODE_PROGRAM = 8'hA0;
    localparam logic [7:0] CODE_BYPASS  = 8'h20;
    localparam logic [7:0] CODE_BYP_OFF = 8'h00;

    function automatic logic cmd_is(bus_cmd_t c, logic [7:0] code,
                                    logic [CMD_ADDR_W-1:0] loc);
        return (c.code == code) && (c.loc == loc);
    endfunction

    function automatic logic [DATA_W-1:0] ident_word(logic [CMD_ADDR_W-1:0] a);
        case (a)
            11'h000: return 16'h00BF;
            11'h001: return 16'h236D;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] query_word(logic [CMD_ADDR_W-1:0] a);
        case (a)
            11'h010: return 16'h0051;
            11'h011: return 16'h0052;
            11'h012: return 16'h0059;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output view_e                 view,
    output logic                  prog_req,
    output logic [ADDR_W-1:0]     prog_addr,
    output logic [DATA_W-1:0]     prog_data
);

    seq_e     step_q, step_d;
    view_e    view_q, view_d;
    logic     nest_q, nest_d;
    logic     fire_d;
    bus_cmd_t cmd;

    assign cmd.code = wdata[7:0];
    assign cmd.loc  = addr[CMD_ADDR_W-1:0];

    always_comb begin
        step_d = step_q;
        view_d = view_q;
        nest_d = nest_q;
        fire_d = 1'b0;
        if (wr_en) begin
            unique case (step_q)
                SEQ_IDLE: begin
                    unique case (view_q)
                        VIEW_ARRAY: begin
                            if (cmd_is(cmd, CODE_KEY_A, LOC_KEY_A)) begin
                                step_d = SEQ_GOT_FIRST;
                            end else if (cmd_is(cmd, CODE_QUERY, LOC_QUERY)) begin
                                view_d = VIEW_QUERY;
                                nest_d = 1'b0;
                            end
                        end
                        VIEW_IDENT: begin
                            if (cmd_is(cmd, CODE_QUERY, LOC_QUERY)) begin
                                view_d = VIEW_QUERY;
                                nest_d = 1'b1;
                            end else begin
                                view_d = VIEW_ARRAY;
                            end
                        end
                        VIEW_QUERY: begin
                            if (cmd.code == CODE_EXIT && nest_q) begin
                                view_d = VIEW_IDENT;
                            end else begin
                                view_d = VIEW_ARRAY;
                            end
                            nest_d = 1'b0;
                        end
                        VIEW_BYPASS: begin
                            if (cmd.code == CODE_PROGRAM) begin
                                step_d = SEQ_WAIT_BYP_DATA;
                            end else begin
                                view_d = VIEW_ARRAY;
                            end
                        end
                        default: view_d = VIEW_ARRAY;
                    endcase
                end
                SEQ_GOT_FIRST: begin
                    if (cmd_is(cmd, CODE_KEY_B, LOC_KEY_B)) begin
                        step_d = SEQ_GOT_SECOND;
                    end else begin
                        step_d = SEQ_IDLE;
                        view_d = VIEW_ARRAY;
                    end
                end
                SEQ_GOT_SECOND: begin
                    step_d = SEQ_IDLE;
                    if (cmd_is(cmd, CODE_IDENT, LOC_KEY_A)) begin
                        view_d = VIEW_IDENT;
                    end else if (cmd_is(cmd, CODE_BYPASS, LOC_KEY_A)) begin
                        view_d = VIEW_BYPASS;
                    end else if (cmd_is(cmd, CODE_PROGRAM, LOC_KEY_A)) begin
                        step_d = SEQ_WAIT_DATA;
                    end else begin
                        view_d = VIEW_ARRAY;
                    end
                end
                SEQ_WAIT_DATA: begin
                    fire_d = 1'b1;
                    step_d = SEQ_IDLE;
                end
                SEQ_WAIT_BYP_DATA: begin
                    fire_d = 1'b1;
                    step_d = SEQ_IDLE;
                end
                default: begin
                    step_d = SEQ_IDLE;
                    view_d = VIEW_ARRAY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= SEQ_IDLE;
            view_q    <= VIEW_ARRAY;
            nest_q    <= 1'b0;
            prog_req  <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            step_q   <= step_d;
            view_q   <= view_d;
            nest_q   <= nest_d;
            prog_req <= fire_d;
            if (fire_d) begin
                prog_addr <= addr;
                prog_data <= wdata;
            end
        end
    end

    assign view = view_q;

    assert_prog_single_R5: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> !prog_req);

    assert_prog_from_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_req) |-> $past(wr_en));

    assert_view_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(view_q));

    assert_bypass_entry_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(view_q == VIEW_BYPASS) |-> $past(step_q == SEQ_GOT_SECOND && wr_en));

    assert_ident_from_query_R4: assert property (@(posedge clk) disable iff (rst)
        (view_q == VIEW_IDENT && $past(view_q) != VIEW_IDENT)
            |-> ($past(view_q) == VIEW_QUERY || $past(step_q) == SEQ_GOT_SECOND));

endmodule

// File: rtl/fcd_array.sv
module fcd_array
    import fcd_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_req,
    input  logic [MEM_AW-1:0] prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] cell_q;
        logic              hit;

        assign hit      = prog_req && (prog_idx == MEM_AW'(g));
        assign words[g] = cell_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '1;
            end else if (hit) begin
                cell_q <= cell_q & prog_data;
            end
        end

        assert_clear_only_R6: assert property (@(posedge clk) disable iff (rst)
            hit |=> ((cell_q & ~$past(cell_q)) == '0));
    end

    assign rd_word = words[rd_idx];

endmodule

// File: rtl/fcd_readmux.sv
module fcd_readmux
    import fcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  view_e                 view,
    input  logic [CMD_ADDR_W-1:0] loc,
    input  logic [DATA_W-1:0]     array_word,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        unique case (view)
            VIEW_IDENT: sel = ident_word(loc);
            VIEW_QUERY: sel = query_word(loc);
            default:    sel = array_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel;
        end
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [15:0]       prog_data
);

    view_e             view;
    logic [DATA_W-1:0] array_word;

    fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .view      (view),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data)
    );

    fcd_array #(.MEM_AW(MEM_AW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .prog_req  (prog_req),
        .prog_idx  (prog_addr[MEM_AW-1:0]),
        .prog_data (prog_data),
        .rd_idx    (addr[MEM_AW-1:0]),
        .rd_word   (array_word)
    );

    fcd_readmux u_rmux (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .view       (view),
        .loc        (addr[CMD_ADDR_W-1:0]),
        .array_word (array_word),
        .rdata      (rdata)
    );

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int WORDS      = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          prog_req;
    logic [AW-1:0] prog_addr;
    logic [15:0]   prog_data;

    int checks = 0;
    int errors = 0;

    // reference model: 0 array, 1 identifier, 2 query, 3 bypass
    int          m_view = 0;
    int          m_phase = 0;   // 0 none, 1 first key, 2 second key, 3 data due, 4 bypass data due
    bit          m_from_id = 0;
    int unsigned m_mem [WORDS];
    bit          m_pend = 0;
    int unsigned m_paddr = 0;
    int unsigned m_pdata = 0;
    logic [15:0] e_rdata = '0;

    flash_cmd_decoder #(.ADDR_W(AW), .MEM_AW(6)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [15:0] model_read(int unsigned a);
        int unsigned low = a % 2048;
        if (m_view == 1) begin
            if (low == 0) return 16'h00BF;
            if (low == 1) return 16'h236D;
            return 16'h0000;
        end
        if (m_view == 2) begin
            if (low == 'h10) return 16'h0051;
            if (low == 'h11) return 16'h0052;
            if (low == 'h12) return 16'h0059;
            return 16'h0000;
        end
        return 16'(m_mem[a % WORDS]);
    endfunction

    task automatic model_write(int unsigned a, int unsigned d, output bit fire);
        int unsigned lo = a % 2048;
        int unsigned c  = d % 256;
        fire = 0;
        if (m_phase == 3 || m_phase == 4) begin
            fire = 1;
            m_phase = 0;
        end else if (m_phase == 1) begin
            if (c == 'h55 && lo == 'h2AA) m_phase = 2;
            else begin m_phase = 0; m_view = 0; end
        end else if (m_phase == 2) begin
            m_phase = 0;
            if (lo == 'h555 && c == 'h90) m_view = 1;
            else if (lo == 'h555 && c == 'h20) m_view = 3;
            else if (lo == 'h555 && c == 'hA0) m_phase = 3;
            else m_view = 0;
        end else begin
            case (m_view)
                0: if (c == 'hAA && lo == 'h555) m_phase = 1;
                   else if (c == 'h98 && lo == 'h55) begin m_view = 2; m_from_id = 0; end
                1: if (c == 'h98 && lo == 'h55) begin m_view = 2; m_from_id = 1; end
                   else m_view = 0;
                2: begin
                    m_view = (c == 'hF0 && m_from_id) ? 1 : 0;
                    m_from_id = 0;
                end
                default: if (c == 'hA0) m_phase = 4; else m_view = 0;
            endcase
        end
    endtask

    task automatic fail_line(string tag, string what, int unsigned act, int unsigned exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // one clock: drive, advance model, compare all outputs after the edge
    task automatic cyc(bit we, bit re, int unsigned a, int unsigned d, string tag);
        bit fire;
        @(negedge clk);
        wr_en = we; rd_en = re; addr = AW'(a); wdata = 16'(d);
        if (re) e_rdata = model_read(a);
        if (m_pend) m_mem[m_paddr % WORDS] = m_mem[m_paddr % WORDS] & m_pdata;
        fire = 0;
        if (we) model_write(a, d, fire);
        m_pend = fire;
        if (fire) begin m_paddr = a; m_pdata = d; end
        @(posedge clk);
        #(CLK_PERIOD/4);
        checks++;
        if (rdata !== e_rdata) fail_line(tag, "rdata", rdata, e_rdata);
        if (prog_req !== m_pend) fail_line(tag, "prog_req", prog_req, m_pend);
        if (m_pend && (prog_addr !== AW'(m_paddr) || prog_data !== 16'(m_pdata)))
            fail_line(tag, "prog word", {prog_addr, prog_data}, {m_paddr[15:0], m_pdata[15:0]});
    endtask

    task automatic wr(int unsigned a, int unsigned d, string tag);
        cyc(1, 0, a, d, tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, tag);
    endtask

    task automatic rd_expect(int unsigned a, logic [15:0] lit, string tag);
        cyc(0, 1, a, 0, tag);
        checks++;
        if (rdata !== lit) fail_line(tag, "read literal", rdata, lit);
    endtask

    task automatic keys(string tag);
        wr('h555, 'hAA, tag);
        wr('h2AA, 'h55, tag);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) m_mem[i] = 'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #(CLK_PERIOD/4);
        checks++;
        if (rdata !== 16'h0 || prog_req !== 1'b0) fail_line("R1", "reset outputs", {rdata, 15'b0, prog_req}, 0);
        rd_expect(0, 16'hFFFF, "R1");
        rd_expect(63, 16'hFFFF, "R1");

        // identifier view
        keys("R2"); wr('h555, 'h90, "R2");
        rd_expect(0, 16'h00BF, "R2");
        rd_expect(1, 16'h236D, "R2");
        rd_expect(5, 16'h0000, "R2");

        // query nested in identifier view
        wr('h55, 'h98, "R3");
        rd_expect('h10, 16'h0051, "R3");
        rd_expect('h11, 16'h0052, "R3");
        rd_expect('h12, 16'h0059, "R3");
        rd_expect('h20, 16'h0000, "R3");
        wr(0, 'hF0, "R4");
        rd_expect(0, 16'h00BF, "R4");
        wr(0, 'hF0, "R4");
        rd_expect(0, 16'hFFFF, "R4");

        // query from array view, exit returns to array
        wr('h55, 'h98, "R3");
        rd_expect('h11, 16'h0052, "R3");
        wr(0, 'hF0, "R4");
        rd_expect(0, 16'hFFFF, "R4");

        // programming and bit clearing
        keys("R5"); wr('h555, 'hA0, "R5"); wr(3, 'h0055, "R5");
        idle("R5");
        rd_expect(3, 16'h0055, "R5");
        keys("R6"); wr('h555, 'hA0, "R6"); wr(3, 'h00A5, "R6");
        idle("R6");
        rd_expect(3, 16'h0005, "R6");
        repeat (3) idle("R11");
        checks++;
        if (rdata !== 16'h0005) fail_line("R11", "held rdata", rdata, 16'h0005);

        // high address bits ignored in matching
        wr('h5555, 'hAA, "R9"); wr('h2AAA, 'h55, "R9"); wr('h5555, 'h90, "R9");
        rd_expect(0, 16'h00BF, "R9");
        wr(0, 'hF0, "R9");

        // bypass programming at arbitrary command addresses
        keys("R7"); wr('h555, 'h20, "R7");
        wr('h1234, 'hA0, "R7"); wr(7, 'h0123, "R7");
        wr(0, 'hA0, "R7"); wr(8, 'h4567, "R7");
        idle("R7");
        rd_expect(7, 16'h0123, "R7");
        rd_expect(8, 16'h4567, "R7");

        // leave bypass, unlocked-less program is ignored
        wr(0, 'h00, "R8");
        wr('h555, 'hA0, "R8"); wr(9, 'h0000, "R8");
        idle("R8");
        rd_expect(9, 16'hFFFF, "R8");

        // broken sequences
        wr('h555, 'hAA, "R10"); wr('h2AA, 'h54, "R10");
        wr('h555, 'hA0, "R10"); wr(10, 'h0000, "R10");
        idle("R10");
        rd_expect(10, 16'hFFFF, "R10");
        keys("R10"); wr('h555, 'h77, "R10");
        rd_expect(0, 16'hFFFF, "R10");
        keys("R10"); wr('h556, 'h90, "R10");
        rd_expect(0, 16'hFFFF, "R10");
        repeat (4) idle("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule